// File: doc/BRIEF.md
# MSI Home Directory with Sharer Vector

This block is the home-side coherence directory that sits beside a shared cache on a point-to-point network. Each entry pairs a block tag and the home copy of the data with a directory state and a sharer mask that has one bit per core. Cores send it read misses, write misses, unblock notices and invalidation acknowledgements. The directory answers each message with at most one response message, registered one cycle after the request. It can also send a registered invalidation mask in that cycle.

A read miss to an uncached or shared block is answered from the home copy. A read miss to a block that one core holds modified is forwarded to that owner, tagged with the requester. The block then stays blocked until the requester returns an unblock carrying the data it received. A write miss invalidates every other holder, and ownership is granted only once all of them have acknowledged. A request that meets a block in either transient state is refused, and the core retries it later.

Top module: `dir_msi_home`

## Requirements
- R1: After reset all entries are uncached (tag 0, data 0), and neither `rsp_valid` nor `inv_valid` is asserted until a request arrives.
- R2: The address is {tag[3:0], index[1:0]}. A read miss (kind 0) to an uncached or shared block produces, one cycle later, a response of kind 0 (data) to the requester, carrying the home data. The requester is then added to the sharer mask.
- R3: A read miss to a block held modified by core k produces, one cycle later, a kind 1 (forward) response to core k. Its `rsp_peer` field holds the requester and its `rsp_addr` field holds the address. The block becomes blocked.
- R4: A read or write miss to a block that is blocked, or that is waiting for acknowledgements, is answered one cycle later with kind 3 (refuse) to the requester. The block's state is unchanged.
- R5: An unblock (kind 2) from the pending requester of a blocked block makes the block shared by the former owner and the requester. The unblock's data replaces the home copy. No response is sent.
- R6: A write miss (kind 1) to a block that other cores hold produces, one cycle later, `inv_valid` with `inv_mask` equal to the sharer mask minus the requester. No response is sent at that point.
- R7: Each acknowledgement (kind 3) from a core still owed one clears that core's debt. The last one produces, one cycle later, a kind 2 (grant) response to the writer with the home data. The writer becomes the sole owner.
- R8: A write miss to a block that no other core holds is granted at once (kind 2, one cycle later), with no invalidation.
- R9: When the block was modified before the write miss, the former owner's acknowledgement data replaces the home copy before the grant. Otherwise acknowledgement data is discarded.
- R10: A miss whose tag differs from the entry's tag is refused when the entry is cached. When the entry is uncached, the miss installs the new tag with data 0.
- R11: An unblock or acknowledgement that does not match a pending transaction (wrong state, wrong core, or a core not owed) is ignored: no output, and no change to the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 unblock, 3 invalidation ack |
| req_core | input | 2 | Sending core |
| req_addr | input | 6 | Block address {tag, index} |
| req_data | input | 16 | Data carried by unblock or ack |
| rsp_valid | output | 1 | Response message valid |
| rsp_kind | output | 2 | 0 data, 1 forward, 2 grant, 3 refuse |
| rsp_core | output | 2 | Destination core |
| rsp_peer | output | 2 | Original requester (forward only) |
| rsp_addr | output | 6 | Block address |
| rsp_data | output | 16 | Block data (data and grant) |
| inv_valid | output | 1 | Invalidations issued this cycle |
| inv_mask | output | 4 | Cores to invalidate |
| inv_addr | output | 6 | Block being invalidated |

## Verification
The assertions assume at most one message per cycle. They also assume that a core sends an acknowledgement only after it has been invalidated, and an unblock only after it has been forwarded data. Without these assumptions, the checks that the owner count is one and that the debt mask is non-empty would not describe real traffic. The directed tests follow these rules: each core's reply is sent only after the directory's matching output has been seen. The stray unblock and acknowledgement cases do break the rules, but they are sent to entries where the design must drop them, so the invariants still hold.

// File: rtl/dir_msi_pkg.sv
package dir_msi_pkg;
    parameter int unsigned CORES  = 4;
    parameter int unsigned IDX_W  = 2;
    parameter int unsigned TAG_W  = 4;
    parameter int unsigned DATA_W = 16;

    localparam int unsigned CORE_W  = $clog2(CORES);
    localparam int unsigned ADDR_W  = TAG_W + IDX_W;
    localparam int unsigned ENTRIES = 1 << IDX_W;

    typedef logic [CORES-1:0]  cmask_t;
    typedef logic [CORE_W-1:0] core_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [TAG_W-1:0]  tag_t;

    typedef enum logic [1:0] {
        MSG_LDMISS = 2'd0,
        MSG_STMISS = 2'd1,
        MSG_UNBLK  = 2'd2,
        MSG_IACK   = 2'd3
    } req_kind_e;

    typedef enum logic [1:0] {
        RSP_DATA  = 2'd0,
        RSP_FWD   = 2'd1,
        RSP_GRANT = 2'd2,
        RSP_NACK  = 2'd3
    } rsp_kind_e;

    typedef enum logic [2:0] {
        DS_IDLE    = 3'd0,
        DS_SHARED  = 3'd1,
        DS_MOD     = 3'd2,
        DS_BLOCKED = 3'd3,
        DS_WAITACK = 3'd4
    } dstate_e;

    typedef struct packed {
        tag_t    tag;
        data_t   data;
        dstate_e state;
        cmask_t  sharers;
        core_t   pend_core;
        cmask_t  pend_mask;
        logic    wb;
    } entry_t;

    typedef struct packed {
        logic      valid;
        rsp_kind_e kind;
        core_t     dst;
        core_t     peer;
        addr_t     addr;
        data_t     data;
    } rsp_msg_t;

    typedef struct packed {
        logic   valid;
        cmask_t mask;
        addr_t  addr;
    } inv_msg_t;

    function automatic cmask_t core_bit(input core_t id);
        cmask_t m;
        m = '0;
        m[id] = 1'b1;
        return m;
    endfunction

    function automatic core_t lowest_core(input cmask_t m);
        core_t id;
        id = '0;
        for (int i = CORES - 1; i >= 0; i--) begin
            if (m[i]) id = core_t'(i);
        end
        return id;
    endfunction
endpackage

// File: rtl/dir_table.sv
module dir_table
    import dir_msi_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  idx_t   rd_idx,
    output entry_t rd_entry,
    input  logic   wr_en,
    input  idx_t   wr_idx,
    input  entry_t wr_entry
);
    entry_t mem [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[g] <= '0;
            end else if (wr_en && wr_idx == idx_t'(g)) begin
                mem[g] <= wr_entry;
            end
        end

        p_owner_single_r7: assert property (@(posedge clk) disable iff (rst)
            (mem[g].state == DS_MOD) |-> ($countones(mem[g].sharers) == 1));
        p_idle_empty_r1: assert property (@(posedge clk) disable iff (rst)
            (mem[g].state == DS_IDLE) |-> (mem[g].sharers == '0));
        p_wait_owed_r6: assert property (@(posedge clk) disable iff (rst)
            (mem[g].state == DS_WAITACK) |-> (mem[g].pend_mask != '0));
    end

    assign rd_entry = mem[rd_idx];
endmodule

// File: rtl/dir_engine.sv
module dir_engine
    import dir_msi_pkg::*;
(
    input  logic     req_valid,
    input  logic [1:0] req_kind,
    input  core_t    req_core,
    input  addr_t    req_addr,
    input  data_t    req_data,
    input  entry_t   cur,
    output logic     wr_en,
    output entry_t   nxt,
    output rsp_msg_t rsp,
    output inv_msg_t inv
);
    tag_t      tag;
    logic      hit, idle, busy;
    cmask_t    me, others, left;
    entry_t    base;
    req_kind_e kind;

    always_comb begin
        kind   = req_kind_e'(req_kind);
        tag    = req_addr[ADDR_W-1:IDX_W];
        hit    = (cur.tag == tag);
        idle   = (cur.state == DS_IDLE);
        busy   = (cur.state == DS_BLOCKED) || (cur.state == DS_WAITACK);
        me     = core_bit(req_core);
        base   = cur;
        if (idle && !hit) begin
            base.tag  = tag;
            base.data = '0;
        end
        others = base.sharers & ~me;
        left   = cur.pend_mask & ~me;

        nxt   = cur;
        wr_en = 1'b0;
        rsp   = '0;
        inv   = '0;
        rsp.addr = req_addr;
        inv.addr = req_addr;

        if (req_valid) begin
            unique case (kind)
                MSG_LDMISS, MSG_STMISS: begin
                    if (busy || (!idle && !hit)) begin
                        rsp.valid = 1'b1;
                        rsp.kind  = RSP_NACK;
                        rsp.dst   = req_core;
                    end else if (kind == MSG_LDMISS) begin
                        wr_en = 1'b1;
                        nxt   = base;
                        if (base.state == DS_MOD) begin
                            rsp.valid     = 1'b1;
                            rsp.kind      = RSP_FWD;
                            rsp.dst       = lowest_core(base.sharers);
                            rsp.peer      = req_core;
                            nxt.state     = DS_BLOCKED;
                            nxt.pend_core = req_core;
                        end else begin
                            rsp.valid   = 1'b1;
                            rsp.kind    = RSP_DATA;
                            rsp.dst     = req_core;
                            rsp.data    = base.data;
                            nxt.state   = DS_SHARED;
                            nxt.sharers = base.sharers | me;
                        end
                    end else begin
                        wr_en = 1'b1;
                        nxt   = base;
                        if (others == '0) begin
                            rsp.valid   = 1'b1;
                            rsp.kind    = RSP_GRANT;
                            rsp.dst     = req_core;
                            rsp.data    = base.data;
                            nxt.state   = DS_MOD;
                            nxt.sharers = me;
                        end else begin
                            inv.valid     = 1'b1;
                            inv.mask      = others;
                            nxt.state     = DS_WAITACK;
                            nxt.pend_core = req_core;
                            nxt.pend_mask = others;
                            nxt.wb        = (base.state == DS_MOD);
                        end
                    end
                end
                MSG_UNBLK: begin
                    if (cur.state == DS_BLOCKED && hit && req_core == cur.pend_core) begin
                        wr_en       = 1'b1;
                        nxt.state   = DS_SHARED;
                        nxt.sharers = cur.sharers | me;
                        nxt.data    = req_data;
                    end
                end
                MSG_IACK: begin
                    if (cur.state == DS_WAITACK && hit && (cur.pend_mask & me) != '0) begin
                        wr_en         = 1'b1;
                        nxt.pend_mask = left;
                        if (cur.wb) nxt.data = req_data;
                        if (left == '0) begin
                            rsp.valid   = 1'b1;
                            rsp.kind    = RSP_GRANT;
                            rsp.dst     = cur.pend_core;
                            rsp.data    = cur.wb ? req_data : cur.data;
                            nxt.state   = DS_MOD;
                            nxt.sharers = core_bit(cur.pend_core);
                            nxt.wb      = 1'b0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/dir_msi_home.sv
module dir_msi_home
    import dir_msi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [CORE_W-1:0] req_core,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              rsp_valid,
    output logic [1:0]        rsp_kind,
    output logic [CORE_W-1:0] rsp_core,
    output logic [CORE_W-1:0] rsp_peer,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [DATA_W-1:0] rsp_data,
    output logic              inv_valid,
    output logic [CORES-1:0]  inv_mask,
    output logic [ADDR_W-1:0] inv_addr
);
    idx_t     idx;
    entry_t   cur, nxt;
    logic     wr_en;
    rsp_msg_t rsp_d, rsp_q;
    inv_msg_t inv_d, inv_q;

    assign idx = req_addr[IDX_W-1:0];

    dir_table u_table (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (idx),
        .rd_entry (cur),
        .wr_en    (wr_en),
        .wr_idx   (idx),
        .wr_entry (nxt)
    );

    dir_engine u_engine (
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .req_core  (req_core),
        .req_addr  (req_addr),
        .req_data  (req_data),
        .cur       (cur),
        .wr_en     (wr_en),
        .nxt       (nxt),
        .rsp       (rsp_d),
        .inv       (inv_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
            inv_q <= '0;
        end else begin
            rsp_q <= rsp_d;
            inv_q <= inv_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_kind  = rsp_q.kind;
    assign rsp_core  = rsp_q.dst;
    assign rsp_peer  = rsp_q.peer;
    assign rsp_addr  = rsp_q.addr;
    assign rsp_data  = rsp_q.data;
    assign inv_valid = inv_q.valid;
    assign inv_mask  = inv_q.mask;
    assign inv_addr  = inv_q.addr;

    p_busy_refused_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_kind[1] &&
         (cur.state == DS_BLOCKED || cur.state == DS_WAITACK))
        |=> (rsp_valid && rsp_kind == 2'(RSP_NACK)));

    p_inv_not_self_r6: assert property (@(posedge clk) disable iff (rst)
        inv_valid |-> ((inv_mask & core_bit($past(req_core))) == '0));

    p_inv_no_rsp_r6: assert property (@(posedge clk) disable iff (rst)
        inv_valid |-> !rsp_valid);

    p_unblock_silent_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == 2'(MSG_UNBLK)) |=> (!rsp_valid && !inv_valid));

    p_fwd_blocks_r3: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_kind == 2'(RSP_FWD)) |-> (rsp_core != rsp_peer));
endmodule

// File: tb/tb_dir_msi_home.sv
`timescale 1ns/1ps
module tb_dir_msi_home;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [1:0]  req_kind;
    logic [1:0]  req_core;
    logic [5:0]  req_addr;
    logic [15:0] req_data;
    logic        rsp_valid;
    logic [1:0]  rsp_kind;
    logic [1:0]  rsp_core;
    logic [1:0]  rsp_peer;
    logic [5:0]  rsp_addr;
    logic [15:0] rsp_data;
    logic        inv_valid;
    logic [3:0]  inv_mask;
    logic [5:0]  inv_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    localparam logic [5:0] A  = 6'd4;   // tag 1, index 0
    localparam logic [5:0] B  = 6'd1;   // tag 0, index 1
    localparam logic [5:0] C  = 6'd8;   // tag 2, index 0
    localparam logic [5:0] D  = 6'd22;  // tag 5, index 2
    localparam logic [5:0] E  = 6'd14;  // tag 3, index 2

    always #5 clk = ~clk;

    dir_msi_home dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_kind(req_kind), .req_core(req_core),
        .req_addr(req_addr), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_core(rsp_core),
        .rsp_peer(rsp_peer), .rsp_addr(rsp_addr), .rsp_data(rsp_data),
        .inv_valid(inv_valid), .inv_mask(inv_mask), .inv_addr(inv_addr)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic send(input logic [1:0] k, input logic [1:0] c,
                        input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_core = c; req_addr = a; req_data = d;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic expect_rsp(input string req, input logic [1:0] k, input logic [1:0] c,
                              input logic [5:0] a, input logic [15:0] d);
        chk({req, " valid"}, {31'd0, rsp_valid}, 32'd1);
        chk({req, " kind"},  {30'd0, rsp_kind}, {30'd0, k});
        chk({req, " core"},  {30'd0, rsp_core}, {30'd0, c});
        chk({req, " addr"},  {26'd0, rsp_addr}, {26'd0, a});
        if (k == 2'd0 || k == 2'd2) chk({req, " data"}, {16'd0, rsp_data}, {16'd0, d});
        chk({req, " no inv"}, {31'd0, inv_valid}, 32'd0);
    endtask

    task automatic expect_quiet(input string req);
        chk({req, " rsp quiet"}, {31'd0, rsp_valid}, 32'd0);
        chk({req, " inv quiet"}, {31'd0, inv_valid}, 32'd0);
    endtask

    task automatic t_reset;
        rst = 1'b1; req_valid = 1'b0; req_kind = '0; req_core = '0; req_addr = '0; req_data = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(posedge clk); #1;
        expect_quiet("R1 reset");
    endtask

    task automatic t_read_shared;
        send(2'd0, 2'd0, A, 16'h0);
        expect_rsp("R2 rd c0", 2'd0, 2'd0, A, 16'h0);
        send(2'd0, 2'd1, A, 16'h0);
        expect_rsp("R2 rd c1", 2'd0, 2'd1, A, 16'h0);
    endtask

    task automatic t_write_invalidate;
        send(2'd1, 2'd2, A, 16'h0);
        chk("R6 inv valid", {31'd0, inv_valid}, 32'd1);
        chk("R6 inv mask", {28'd0, inv_mask}, 32'h3);
        chk("R6 inv addr", {26'd0, inv_addr}, {26'd0, A});
        chk("R6 no grant yet", {31'd0, rsp_valid}, 32'd0);
        send(2'd0, 2'd3, A, 16'h0);
        expect_rsp("R4 nack during wait", 2'd3, 2'd3, A, 16'h0);
        send(2'd3, 2'd0, A, 16'h9999);
        expect_quiet("R7 first ack");
        send(2'd3, 2'd0, A, 16'h7777);
        expect_quiet("R11 repeated ack");
        send(2'd3, 2'd1, A, 16'h8888);
        expect_rsp("R9 grant keeps home data", 2'd2, 2'd2, A, 16'h0);
    endtask

    task automatic t_forward;
        send(2'd0, 2'd0, A, 16'h0);
        expect_rsp("R3 forward", 2'd1, 2'd2, A, 16'h0);
        chk("R3 peer", {30'd0, rsp_peer}, 32'd0);
        send(2'd1, 2'd1, A, 16'h0);
        expect_rsp("R4 nack while blocked", 2'd3, 2'd1, A, 16'h0);
        send(2'd3, 2'd3, A, 16'h5555);
        expect_quiet("R11 stray ack");
        send(2'd2, 2'd1, A, 16'h6666);
        expect_quiet("R11 unblock wrong core");
        send(2'd2, 2'd0, A, 16'h1234);
        expect_quiet("R5 unblock");
    endtask

    task automatic t_after_unblock;
        send(2'd1, 2'd3, A, 16'h0);
        chk("R5 inv owner+reader", {28'd0, inv_mask}, 32'h5);
        chk("R5 inv valid", {31'd0, inv_valid}, 32'd1);
        send(2'd3, 2'd0, A, 16'h0);
        expect_quiet("R7 partial ack");
        send(2'd3, 2'd2, A, 16'h0);
        expect_rsp("R5 unblock data in grant", 2'd2, 2'd3, A, 16'h1234);
    endtask

    task automatic t_writeback;
        send(2'd1, 2'd1, A, 16'h0);
        chk("R9 inv owner", {28'd0, inv_mask}, 32'h8);
        send(2'd3, 2'd3, A, 16'hBEEF);
        expect_rsp("R9 owner data to writer", 2'd2, 2'd1, A, 16'hBEEF);
    endtask

    task automatic t_sole_write;
        send(2'd0, 2'd2, B, 16'h0);
        expect_rsp("R2 rd other entry", 2'd0, 2'd2, B, 16'h0);
        send(2'd1, 2'd2, B, 16'h0);
        expect_rsp("R8 immediate grant", 2'd2, 2'd2, B, 16'h0);
    endtask

    task automatic t_tags;
        send(2'd0, 2'd0, C, 16'h0);
        expect_rsp("R10 tag conflict", 2'd3, 2'd0, C, 16'h0);
        send(2'd0, 2'd3, D, 16'h0);
        expect_rsp("R10 install", 2'd0, 2'd3, D, 16'h0);
        send(2'd1, 2'd0, E, 16'h0);
        expect_rsp("R10 conflict shared", 2'd3, 2'd0, E, 16'h0);
    endtask

    task automatic t_stray;
        send(2'd2, 2'd0, A, 16'hAAAA);
        expect_quiet("R11 unblock to modified");
        send(2'd0, 2'd0, A, 16'h0);
        expect_rsp("R7 sole owner forward", 2'd1, 2'd1, A, 16'h0);
        chk("R11 peer", {30'd0, rsp_peer}, 32'd0);
        send(2'd2, 2'd0, A, 16'h4321);
        send(2'd0, 2'd2, A, 16'h0);
        expect_rsp("R5 reread after unblock", 2'd0, 2'd2, A, 16'h4321);
    endtask

    initial begin
        t_reset();
        t_read_shared();
        t_write_invalidate();
        t_forward();
        t_after_unblock();
        t_writeback();
        t_sole_write();
        t_tags();
        t_stray();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule